// File: doc/BRIEF.md
# Pin-Group External Interrupt Sensitivity Unit

This unit watches four groups of port pins and raises one pending request per group toward the interrupt controller. Each group's pins are first passed through a two-flop synchroniser. They are then reduced to one combined signal: the NAND of the group's pins, which goes low only when every pin in the group is high. A per-group sensitivity setting then chooses what sets the request: a rising edge, a falling edge, either edge, or a falling edge that also holds the request for as long as the combined signal stays low.

A single configuration word holds the four two-bit mode fields and two polarity bits. The polarity bits exist for groups 0 and 2 only, and each one inverts that group's sense. Software may change the word only while the global interrupt mask level is 3, and any field that actually changes clears the matching latched request. Each group has an acknowledge input that clears its edge-latched request.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, every pending output is 0, every mode field is 00 and both polarity bits are 0.
- R2: Group 0 is port A bits 3..0, group 1 is port F bits 2..0, group 2 is port B bits 3..0 and group 3 is port B bits 7..4. A group's combined signal is the NAND of its synchronised pins.
- R3: Mode encoding per group: 01 sets the request on a rising edge of the combined signal, 10 on a falling edge and 11 on either edge. The latched request appears at the output three rising clock edges after the pin change.
- R4: Mode 00 latches the request on a falling edge. It also drives the pending output high while the combined signal is low, two clock edges after the pin change, and this level term is not cleared by acknowledge.
- R5: Configuration bit 8 inverts the sense of group 0 and bit 9 inverts the sense of group 2. With the bit set, mode 00 becomes rising edge plus high level. Changing a polarity bit by itself never produces an edge.
- R6: A configuration write is accepted only when the mask level input equals 2'b11. Otherwise the configuration is left unchanged.
- R7: Configuration layout: bits [2k+1:2k] are the mode of group k. An accepted write that changes a group's mode, or its polarity bit for groups 0 and 2, clears that group's latched request at the write edge. This takes priority over a new edge. A group whose field is unchanged keeps its request.
- R8: An acknowledge on group k clears its latched request at the next clock edge, unless a new triggering edge is detected in that same cycle, in which case the request stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_a_i | input | 4 | Port A pins feeding group 0 |
| port_f_i | input | 3 | Port F pins feeding group 1 |
| port_b_i | input | 8 | Port B pins feeding groups 2 and 3 |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 10 | Configuration write value |
| mask_lvl_i | input | 2 | Current global interrupt mask level |
| ack_i | input | 4 | Per-group acknowledge |
| pend_o | output | 4 | Per-group pending request |

## Verification
A pin change reaches the level term of the pending output after two clock edges and reaches the edge latch after three. Acknowledge and configuration writes act on the latch at the very next edge. The bench drives every input on the falling clock edge. At each rising edge it advances a cycle model that keeps its own two-stage pin pipeline. It compares the outputs at the following falling edge, so each result is sampled in the cycle in which that latency says it is due.

// File: rtl/ext_irq_sense.sv
module ext_irq_sense #(
  parameter int PA_W = 4,
  parameter int PF_W = 3,
  parameter int PB_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PA_W-1:0] port_a_i,
  input  logic [PF_W-1:0] port_f_i,
  input  logic [PB_W-1:0] port_b_i,
  input  logic            cfg_we_i,
  input  logic [9:0]      cfg_wdata_i,
  input  logic [1:0]      mask_lvl_i,
  input  logic [3:0]      ack_i,
  output logic [3:0]      pend_o
);
  localparam int HB = PB_W / 2;

  logic [PA_W-1:0] pa1, pa2;
  logic [PF_W-1:0] pf1, pf2;
  logic [PB_W-1:0] pb1, pb2;
  logic [9:0]      cfg_q;
  logic [3:0]      comb, comb_q, latch;
  logic [3:0]      pol_old, pol_new, chg, sense, sense_q, set;
  logic            wr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa1 <= '0; pa2 <= '0;
      pf1 <= '0; pf2 <= '0;
      pb1 <= '0; pb2 <= '0;
    end else begin
      pa1 <= port_a_i; pa2 <= pa1;
      pf1 <= port_f_i; pf2 <= pf1;
      pb1 <= port_b_i; pb2 <= pb1;
    end
  end

  assign comb    = {~&pb2[PB_W-1:HB], ~&pb2[HB-1:0], ~&pf2, ~&pa2};
  assign wr_ok   = cfg_we_i && (mask_lvl_i == 2'b11);
  assign pol_old = {1'b0, cfg_q[9], 1'b0, cfg_q[8]};
  assign pol_new = {1'b0, cfg_wdata_i[9], 1'b0, cfg_wdata_i[8]};
  assign sense   = comb ^ pol_old;
  assign sense_q = comb_q ^ pol_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      comb_q <= 4'hF;
    end else begin
      comb_q <= comb;
      if (wr_ok) cfg_q <= cfg_wdata_i;
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_src
    logic [1:0] mode, mode_new;
    logic       rise, fall;

    assign mode     = cfg_q[2*k+1:2*k];
    assign mode_new = cfg_wdata_i[2*k+1:2*k];
    assign chg[k]   = wr_ok && ({pol_new[k], mode_new} != {pol_old[k], mode});
    assign rise     = sense[k] & ~sense_q[k];
    assign fall     = ~sense[k] & sense_q[k];
    assign set[k]   = (mode == 2'b01) ? rise :
                      (mode == 2'b11) ? (rise | fall) : fall;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        latch[k] <= 1'b0;
      else if (chg[k])   latch[k] <= 1'b0;
      else if (set[k])   latch[k] <= 1'b1;
      else if (ack_i[k]) latch[k] <= 1'b0;
    end

    assign pend_o[k] = latch[k] | ((mode == 2'b00) & ~sense[k]);

    AST_CHG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      chg[k] |=> !latch[k]); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i[k] && !set[k] && !chg[k]) |=> !latch[k]); // R8
    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (set[k] && !chg[k]) |=> pend_o[k]); // R3
    AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00 && !sense[k]) |-> pend_o[k]); // R4
  end

  AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && mask_lvl_i != 2'b11) |=> $stable(cfg_q)); // R6
  AST_POL_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(comb) && $stable(comb_q) && comb == comb_q) |-> set == 4'b0); // R5
endmodule

// File: tb/test_ext_irq_sense.sv
module test_ext_irq_sense;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pa = '0;
  logic [2:0] pf = '0;
  logic [7:0] pb = '0;
  logic       we = 1'b0;
  logic [9:0] wd = '0;
  logic [1:0] ml = '0;
  logic [3:0] ack = '0;
  logic [3:0] pend;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  logic [3:0] m_pa1, m_pa2;
  logic [2:0] m_pf1, m_pf2;
  logic [7:0] m_pb1, m_pb2;
  logic [9:0] m_cfg;
  logic [3:0] m_cq, m_lat;

  ext_irq_sense i_ext_irq_sense (
    .clk(clk), .rst_n(rst_n), .port_a_i(pa), .port_f_i(pf), .port_b_i(pb),
    .cfg_we_i(we), .cfg_wdata_i(wd), .mask_lvl_i(ml), .ack_i(ack), .pend_o(pend)
  );

  always #4 clk = ~clk;

  function automatic logic [3:0] grp(logic [3:0] a, logic [2:0] f, logic [7:0] b);
    return {~&b[7:4], ~&b[3:0], ~&f, ~&a};
  endfunction

  function automatic logic [3:0] pol_of(logic [9:0] c);
    return {1'b0, c[9], 1'b0, c[8]};
  endfunction

  function automatic logic [3:0] exp_pend();
    logic [3:0] s = grp(m_pa2, m_pf2, m_pb2) ^ pol_of(m_cfg);
    logic [3:0] r;
    for (int k = 0; k < 4; k++)
      r[k] = m_lat[k] | ((m_cfg[2*k+:2] == 2'b00) & ~s[k]);
    return r;
  endfunction

  task automatic model_reset();
    m_pa1 = '0; m_pa2 = '0; m_pf1 = '0; m_pf2 = '0; m_pb1 = '0; m_pb2 = '0;
    m_cfg = '0; m_cq = 4'hF; m_lat = '0;
  endtask

  task automatic model_edge();
    logic [3:0] c  = grp(m_pa2, m_pf2, m_pb2);
    logic [3:0] po = pol_of(m_cfg);
    logic [3:0] pn = pol_of(wd);
    logic [3:0] s  = c ^ po;
    logic [3:0] sq = m_cq ^ po;
    logic       ok = we && ml == 2'b11;
    for (int k = 0; k < 4; k++) begin
      logic rise = s[k] & ~sq[k];
      logic fall = ~s[k] & sq[k];
      logic [1:0] md = m_cfg[2*k+:2];
      logic st = (md == 2'b01) ? rise : (md == 2'b11) ? (rise | fall) : fall;
      logic ch = ok && ({pn[k], wd[2*k+:2]} != {po[k], md});
      if (ch) m_lat[k] = 1'b0;
      else if (st) m_lat[k] = 1'b1;
      else if (ack[k]) m_lat[k] = 1'b0;
    end
    if (ok) m_cfg = wd;
    m_cq = c;
    m_pa2 = m_pa1; m_pa1 = pa;
    m_pf2 = m_pf1; m_pf1 = pf;
    m_pb2 = m_pb1; m_pb1 = pb;
  endtask

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: pend=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(string req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(req, pend, exp_pend());
  endtask

  task automatic steps(int n, string req);
    for (int i = 0; i < n; i++) step(req);
  endtask

  task automatic wr(logic [9:0] v, logic [1:0] lvl, string req);
    we = 1'b1; wd = v; ml = lvl;
    step(req);
    we = 1'b0; ml = 2'b00;
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check("R1", pend, 4'b0000);
    rst_n = 1'b1;
    steps(3, "R1");
    check("R1", pend, 4'b0000);

    // R6: blocked write leaves mode 00 on group 3; its level then shows
    wr(10'h0C0, 2'b10, "R6");
    pb = 8'hF0; steps(2, "R6");
    check("R6", pend, 4'b1000);
    @(posedge clk); model_edge(); @(negedge clk);
    ack = 4'b1000; step("R4"); ack = '0;
    check("R4", pend, 4'b1000);
    pb = 8'h00; steps(3, "R4");
    check("R4", pend, 4'b0000);

    // R2/R3: group 1 falling-edge mode
    wr(10'h008, 2'b11, "R3");
    pf = 3'b011; steps(4, "R2");
    check("R2", pend, 4'b0000);
    pf = 3'b111; steps(2, "R3");
    check("R3", pend, 4'b0000);
    step("R3");
    check("R3", pend, 4'b0010);

    // R7: rewrite same value keeps, changed field clears
    wr(10'h008, 2'b11, "R7");
    check("R7", pend, 4'b0010);
    wr(10'h00C, 2'b11, "R7");
    check("R7", pend, 4'b0000);
    pf = 3'b000; steps(3, "R3");
    check("R3", pend, 4'b0010);

    // R8: acknowledge
    ack = 4'b0010; step("R8"); ack = '0;
    check("R8", pend, 4'b0000);

    // R5: group 0 inverted, mode 00 means rising + high level; pol change alone no edge
    wr(10'h100, 2'b11, "R5");
    steps(3, "R5");
    check("R5", pend, 4'b0001);
    pa = 4'hF; steps(3, "R5");
    check("R5", pend, 4'b0000);
    pa = 4'h0; steps(3, "R5");
    check("R5", pend, 4'b0001);
    wr(10'h000, 2'b11, "R5");
    steps(3, "R5");
    check("R5", pend, 4'b0000);

    // random phase
    void'($urandom(32'd1357));
    for (int i = 0; i < 4000; i++) begin
      pa  = ($urandom % 4 == 0) ? 4'($urandom) : (($urandom % 2) ? 4'hF : pa);
      pf  = ($urandom % 4 == 0) ? 3'($urandom) : (($urandom % 2) ? 3'h7 : pf);
      pb  = ($urandom % 4 == 0) ? 8'($urandom) : (($urandom % 3 == 0) ? ~pb : pb);
      ack = 4'($urandom) & 4'($urandom);
      we  = ($urandom % 8 == 0);
      wd  = 10'($urandom);
      ml  = 2'($urandom | ($urandom % 2 ? 2'b11 : 2'b00));
      step("R3 R4 R7 R8");
    end
    we = 0; ack = '0;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule